// File: doc/BRIEF.md
# Memory Protection Region Checker

This block screens every processor access against a table of sixteen programmable protection regions. Each region has a power-of-two size, a base address aligned to that size, eight equal subregions that can be switched off one by one, and a set of attributes: memory-type bits, a shareable bit, an execute-never bit and a 3-bit permission code. When regions overlap, the enabled region with the highest index supplies the attributes. An access that lands in no region takes a fallback path. If the background option is on, a privileged access is let through with no attributes. Any other such access faults.

Software programs the table through a small word-addressed register interface. One register selects a region. A base register and an attribute/size register, plus three alias pairs of the same two, all act on the selected region. A control word holds the global enable and the background enable. A read-only information word gives the region count. Each access is presented for one cycle. Its result appears on the result port one clock later: hit, winning region index, memory-type and shareability bits, execute-never, and fault.

Top module: `prot_region_chk`

## Requirements
- R1: After reset the global enable is 0, the background enable is 1 (control word reads 0x4), the selector reads 0, every base reads 0, and every attribute word reads 0x0108_0000 (TEX=1, AP=1, region disabled, size field 0, no subregion disabled, B=C=S=XN=0).
- R2: While the global enable (control bit 0) is 0, every access gets hit=0, fault=0, region 0 and all attribute outputs 0, whatever the table holds.
- R3: The attribute word bits [5:1] hold a size code N, and the region spans 2^(N+1) bytes. Codes below 4 act as 4 (32 bytes). Only address bits above bit N are compared with the base, so base bits below the region size are ignored.
- R4: When several enabled regions match, the highest-indexed one wins: its index goes out on res_region and its attributes on the attribute outputs.
- R5: Attribute word bits [15:8] disable subregions. Bit 8+k removes the k-th eighth of the region, counted from the base. An address in a removed subregion does not match that region, so a lower region or the fallback can still take it.
- R6: With the global enable on and the background enable (control bit 2) on, a privileged access that matches no region gets hit=0 and fault=0.
- R7: With the global enable on, an unprivileged access that matches no region faults. A privileged one also faults when the background enable is 0.
- R8: The permission code sits in attribute bits [26:24]. Code 0 allows nothing. Code 1 allows privileged read and write. Code 2 allows privileged read and write and unprivileged read. Code 3 allows read and write at both levels. Code 5 allows privileged read only. Code 6 allows read only at both levels. Codes 4 and 7 allow nothing. A denied access on a hit faults.
- R9: Access kind 0 is a read, 1 a write, 2 an instruction fetch, and 3 counts as a read. A fetch that hits a region with XN (attribute bit 28) set faults, whatever the permission code.
- R10: Register word indices: 0 information (bits [15:8] = 16, read-only), 1 control, 2 region selector (bits [3:0]), 3 base, 4 attribute. Indices 5/6, 7/8 and 9/10 are alias base/attribute pairs. Every base and attribute view acts on the selected region. Base bits [4:0] read as 0. Writes to index 0 and to indices 11 to 15 change nothing.
- R11: res_valid follows acc_valid one clock later, and back-to-back accesses give back-to-back results. On a cycle with res_valid at 0, all other result outputs are 0.
- R12: On a hit, res_tex, res_b, res_c, res_s and res_xn carry the winning region's TEX (bits [21:19]), B (bit 16), C (bit 17), S (bit 18) and XN (bit 28) fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr (combinational) |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | 32 | Access address |
| acc_priv | input | 1 | 1 = privileged access |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 read |
| res_valid | output | 1 | Result present |
| res_hit | output | 1 | Access matched an enabled region |
| res_region | output | 4 | Winning region index |
| res_tex | output | 3 | Winning TEX field |
| res_b | output | 1 | Winning B bit |
| res_c | output | 1 | Winning C bit |
| res_s | output | 1 | Winning shareable bit |
| res_xn | output | 1 | Winning execute-never bit |
| res_fault | output | 1 | Access is denied |

## Verification
The bound checker watches, on every cycle, the properties that need no table contents. The result follows the access by one cycle and is all zero when idle. A disabled block never hits or faults. An unprivileged access always hits or faults. A privileged access with the fallback on never misses into a fault. A fetch never passes a region marked execute-never. The information word always reports sixteen regions. The bench's scenarios alone can show the rest. Those cover which of several overlapping regions wins, the size clamp and alignment masking, disabled subregions falling through to a lower region, the full permission-code matrix, alias decoding, and ignored writes. For these it compares every result against a behavioural table model on every clock.

// File: rtl/mpr_pkg.sv
package mpr_pkg;

    // access kinds presented on acc_kind
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    // register word indices
    typedef enum logic [3:0] {
        RG_INFO    = 4'd0,
        RG_CTRL    = 4'd1,
        RG_SEL     = 4'd2,
        RG_BASE    = 4'd3,
        RG_ATTR    = 4'd4,
        RG_BASE_X1 = 4'd5,
        RG_ATTR_X1 = 4'd6,
        RG_BASE_X2 = 4'd7,
        RG_ATTR_X2 = 4'd8,
        RG_BASE_X3 = 4'd9,
        RG_ATTR_X3 = 4'd10
    } cfg_reg_e;

    localparam int CTRL_EN_BIT = 0;
    localparam int CTRL_BG_BIT = 2;
    localparam int BASE_LSB    = 5;

    typedef struct packed {
        logic       xn;
        logic [2:0] ap;
        logic [2:0] tex;
        logic       s;
        logic       c;
        logic       b;
        logic [7:0] srd;
        logic [4:0] size;
        logic       en;
    } region_attr_t;

    localparam region_attr_t ATTR_RESET = '{
        xn: 1'b0, ap: 3'd1, tex: 3'd1, s: 1'b0, c: 1'b0, b: 1'b0,
        srd: 8'h00, size: 5'd0, en: 1'b0
    };

    function automatic logic [31:0] attr_to_word(input region_attr_t a);
        logic [31:0] w;
        w        = '0;
        w[0]     = a.en;
        w[5:1]   = a.size;
        w[15:8]  = a.srd;
        w[16]    = a.b;
        w[17]    = a.c;
        w[18]    = a.s;
        w[21:19] = a.tex;
        w[26:24] = a.ap;
        w[28]    = a.xn;
        return w;
    endfunction

    function automatic region_attr_t word_to_attr(input logic [31:0] w);
        region_attr_t a;
        a.en   = w[0];
        a.size = w[5:1];
        a.srd  = w[15:8];
        a.b    = w[16];
        a.c    = w[17];
        a.s    = w[18];
        a.tex  = w[21:19];
        a.ap   = w[26:24];
        a.xn   = w[28];
        return a;
    endfunction

endpackage

// File: rtl/mpr_regfile.sv
module mpr_regfile
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   cfg_we,
    input  logic [3:0]                             cfg_addr,
    input  logic [31:0]                            cfg_wdata,
    output logic [31:0]                            cfg_rdata,
    output logic                                   ctl_en,
    output logic                                   ctl_bg,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]     base_o,
    output region_attr_t [NUM_REGIONS-1:0]         attr_o
);

    logic [IDX_W-1:0] sel_q;
    logic             en_q;
    logic             bg_q;
    logic             is_base;
    logic             is_attr;

    // odd indices 3..9 are base views, even 4..10 attribute views
    always_comb begin
        is_base = (cfg_addr >= RG_BASE) && (cfg_addr <= RG_BASE_X3) && cfg_addr[0];
        is_attr = (cfg_addr >= RG_ATTR) && (cfg_addr <= RG_ATTR_X3) && !cfg_addr[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
            en_q  <= 1'b0;
            bg_q  <= 1'b1;
        end else if (cfg_we) begin
            if (cfg_addr == RG_CTRL) begin
                en_q <= cfg_wdata[CTRL_EN_BIT];
                bg_q <= cfg_wdata[CTRL_BG_BIT];
            end
            if (cfg_addr == RG_SEL) begin
                sel_q <= cfg_wdata[IDX_W-1:0];
            end
        end
    end

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        logic [ADDR_W-1:0] base_r;
        region_attr_t      attr_r;
        logic              hit_sel;

        assign hit_sel = cfg_we && (sel_q == IDX_W'(r));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_r <= '0;
                attr_r <= ATTR_RESET;
            end else if (hit_sel) begin
                if (is_base) begin
                    base_r <= {cfg_wdata[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
                end
                if (is_attr) begin
                    attr_r <= word_to_attr(cfg_wdata);
                end
            end
        end

        assign base_o[r] = base_r;
        assign attr_o[r] = attr_r;
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_addr == RG_INFO) begin
            cfg_rdata[15:8] = 8'(NUM_REGIONS);
        end else if (cfg_addr == RG_CTRL) begin
            cfg_rdata[CTRL_EN_BIT] = en_q;
            cfg_rdata[CTRL_BG_BIT] = bg_q;
        end else if (cfg_addr == RG_SEL) begin
            cfg_rdata[IDX_W-1:0] = sel_q;
        end else if (is_base) begin
            cfg_rdata[ADDR_W-1:0] = base_o[sel_q];
        end else if (is_attr) begin
            cfg_rdata = attr_to_word(attr_o[sel_q]);
        end
    end

    assign ctl_en = en_q;
    assign ctl_bg = bg_q;

endmodule

// File: rtl/mpr_region_match.sv
module mpr_region_match
    import mpr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  region_attr_t      attr_i,
    output logic              hit_o
);

    logic [4:0]        n_eff;
    logic [ADDR_W-1:0] keep;
    logic [2:0]        sub;

    always_comb begin
        n_eff = (attr_i.size < 5'd4) ? 5'd4 : attr_i.size;
        for (int k = 0; k < ADDR_W; k++) begin
            keep[k] = (k > int'(n_eff));
        end
        sub   = 3'(addr_i >> (n_eff - 5'd2));
        hit_o = attr_i.en
              && (((addr_i ^ base_i) & keep) == '0)
              && !attr_i.srd[sub];
    end

endmodule

// File: rtl/mpr_prio_pick.sv
module mpr_prio_pick #(
    parameter int NUM_REGIONS = 16,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic [NUM_REGIONS-1:0] hit_i,
    output logic                   any_o,
    output logic [IDX_W-1:0]       idx_o
);

    // scanning upward lets the last (highest) hit overwrite lower ones
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int r = 0; r < NUM_REGIONS; r++) begin
            if (hit_i[r]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(r);
            end
        end
    end

endmodule

// File: rtl/mpr_perm_check.sv
module mpr_perm_check
    import mpr_pkg::*;
(
    input  logic [2:0] ap_i,
    input  logic       xn_i,
    input  logic       priv_i,
    input  logic [1:0] kind_i,
    output logic       ok_o
);

    logic rd_ok;
    logic wr_ok;

    always_comb begin
        rd_ok = 1'b0;
        wr_ok = 1'b0;
        unique case (ap_i)
            3'd1: begin rd_ok = priv_i; wr_ok = priv_i; end
            3'd2: begin rd_ok = 1'b1;   wr_ok = priv_i; end
            3'd3: begin rd_ok = 1'b1;   wr_ok = 1'b1;   end
            3'd5: begin rd_ok = priv_i; wr_ok = 1'b0;   end
            3'd6: begin rd_ok = 1'b1;   wr_ok = 1'b0;   end
            default: begin rd_ok = 1'b0; wr_ok = 1'b0;  end
        endcase
        ok_o = (kind_i == ACC_WRITE) ? wr_ok : rd_ok;
        if ((kind_i == ACC_FETCH) && xn_i) begin
            ok_o = 1'b0;
        end
    end

endmodule

// File: rtl/prot_region_chk.sv
module prot_region_chk
    import mpr_pkg::*;
#(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32,
    localparam int IDX_W      = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [3:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_priv,
    input  logic [1:0]        acc_kind,
    output logic              res_valid,
    output logic              res_hit,
    output logic [IDX_W-1:0]  res_region,
    output logic [2:0]        res_tex,
    output logic              res_b,
    output logic              res_c,
    output logic              res_s,
    output logic              res_xn,
    output logic              res_fault
);

    logic                               ctl_en;
    logic                               ctl_bg;
    logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_all;
    region_attr_t [NUM_REGIONS-1:0]     attr_all;
    logic [NUM_REGIONS-1:0]             hit_vec;
    logic                               any_hit;
    logic [IDX_W-1:0]                   win_idx;
    region_attr_t                       win_attr;
    logic                               perm_ok;

    logic             nxt_valid;
    logic             nxt_hit;
    logic [IDX_W-1:0] nxt_region;
    logic [2:0]       nxt_tex;
    logic             nxt_b;
    logic             nxt_c;
    logic             nxt_s;
    logic             nxt_xn;
    logic             nxt_fault;

    mpr_regfile #(
        .NUM_REGIONS (NUM_REGIONS),
        .ADDR_W      (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .ctl_en    (ctl_en),
        .ctl_bg    (ctl_bg),
        .base_o    (base_all),
        .attr_o    (attr_all)
    );

    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_match
        mpr_region_match #(
            .ADDR_W (ADDR_W)
        ) u_match (
            .addr_i (acc_addr),
            .base_i (base_all[r]),
            .attr_i (attr_all[r]),
            .hit_o  (hit_vec[r])
        );
    end

    mpr_prio_pick #(
        .NUM_REGIONS (NUM_REGIONS)
    ) u_pick (
        .hit_i (hit_vec),
        .any_o (any_hit),
        .idx_o (win_idx)
    );

    assign win_attr = attr_all[win_idx];

    mpr_perm_check u_perm (
        .ap_i   (win_attr.ap),
        .xn_i   (win_attr.xn),
        .priv_i (acc_priv),
        .kind_i (acc_kind),
        .ok_o   (perm_ok)
    );

    always_comb begin
        nxt_valid  = acc_valid;
        nxt_hit    = 1'b0;
        nxt_region = '0;
        nxt_tex    = '0;
        nxt_b      = 1'b0;
        nxt_c      = 1'b0;
        nxt_s      = 1'b0;
        nxt_xn     = 1'b0;
        nxt_fault  = 1'b0;
        if (acc_valid && ctl_en) begin
            if (any_hit) begin
                nxt_hit    = 1'b1;
                nxt_region = win_idx;
                nxt_tex    = win_attr.tex;
                nxt_b      = win_attr.b;
                nxt_c      = win_attr.c;
                nxt_s      = win_attr.s;
                nxt_xn     = win_attr.xn;
                nxt_fault  = !perm_ok;
            end else begin
                nxt_fault  = !(acc_priv && ctl_bg);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid  <= 1'b0;
            res_hit    <= 1'b0;
            res_region <= '0;
            res_tex    <= '0;
            res_b      <= 1'b0;
            res_c      <= 1'b0;
            res_s      <= 1'b0;
            res_xn     <= 1'b0;
            res_fault  <= 1'b0;
        end else begin
            res_valid  <= nxt_valid;
            res_hit    <= nxt_hit;
            res_region <= nxt_region;
            res_tex    <= nxt_tex;
            res_b      <= nxt_b;
            res_c      <= nxt_c;
            res_s      <= nxt_s;
            res_xn     <= nxt_xn;
            res_fault  <= nxt_fault;
        end
    end

endmodule

// File: rtl/mpr_chk.sv
module mpr_chk #(
    parameter int NREG = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ctl_en,
    input logic        ctl_bg,
    input logic        acc_valid,
    input logic        acc_priv,
    input logic [1:0]  acc_kind,
    input logic [3:0]  cfg_addr,
    input logic [31:0] cfg_rdata,
    input logic        res_valid,
    input logic        res_hit,
    input logic        res_xn,
    input logic        res_fault
);

    // R11: one-cycle result latency
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> res_valid);

    a_r11_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !res_valid);

    // R11: idle result is all zero
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> (!res_hit && !res_fault && !res_xn));

    // R2: disabled block neither hits nor faults
    a_r2_disabled_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !ctl_en) |=> (!res_hit && !res_fault));

    // R7: unprivileged access either hits or faults
    a_r7_user_miss_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctl_en && !acc_priv) |=> (res_hit || res_fault));

    // R6: privileged miss with fallback on is allowed
    a_r6_priv_fallback: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctl_en && ctl_bg && acc_priv) |=> (res_hit || !res_fault));

    // R9: fetch never passes an execute-never region
    a_r9_xn_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && ctl_en && (acc_kind == 2'd2)) |=> !(res_hit && res_xn && !res_fault));

    // R10: information word reports the region count
    a_r10_info_word: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr == 4'd0) |-> (cfg_rdata[15:8] == 8'(NREG)));

endmodule

bind prot_region_chk mpr_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_en    (ctl_en),
    .ctl_bg    (ctl_bg),
    .acc_valid (acc_valid),
    .acc_priv  (acc_priv),
    .acc_kind  (acc_kind),
    .cfg_addr  (cfg_addr),
    .cfg_rdata (cfg_rdata),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_xn    (res_xn),
    .res_fault (res_fault)
);

// File: tb/prot_region_chk_tb_top.sv
module prot_region_chk_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_priv = 1'b0;
    logic [1:0]  acc_kind = '0;
    logic        res_valid, res_hit, res_b, res_c, res_s, res_xn, res_fault;
    logic [3:0]  res_region;
    logic [2:0]  res_tex;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_region_chk dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
        .acc_addr(acc_addr), .acc_priv(acc_priv), .acc_kind(acc_kind),
        .res_valid(res_valid), .res_hit(res_hit), .res_region(res_region),
        .res_tex(res_tex), .res_b(res_b), .res_c(res_c), .res_s(res_s),
        .res_xn(res_xn), .res_fault(res_fault)
    );

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R1";

    // behavioural model state
    logic [31:0] m_base [16];
    logic [31:0] m_rasr [16];
    logic        m_en, m_bg;
    int          m_sel;

    logic        e_valid, e_hit, e_b, e_c, e_s, e_xn, e_fault;
    int          e_region;
    logic [2:0]  e_tex;

    function automatic logic [31:0] mk(input bit en, input int n, input int srd,
                                       input bit b, input bit c, input bit s,
                                       input int tex, input int ap, input bit xn);
        logic [31:0] w;
        w = 32'(en) | (32'(n) << 1) | (32'(srd & 255) << 8) | (32'(b) << 16)
          | (32'(c) << 17) | (32'(s) << 18) | (32'(tex & 7) << 19)
          | (32'(ap & 7) << 24) | (32'(xn) << 28);
        return w;
    endfunction

    function automatic bit m_hits(input int r, input logic [31:0] a);
        longint unsigned span, sub;
        int n;
        if (!m_rasr[r][0]) return 1'b0;
        n = int'(m_rasr[r][5:1]);
        if (n < 4) n = 4;
        span = 64'd1 << (n + 1);
        if ((64'(a) / span) != (64'(m_base[r]) / span)) return 1'b0;
        sub = (64'(a) % span) / (span / 8);
        return !m_rasr[r][8 + int'(sub)];
    endfunction

    function automatic bit m_allowed(input int ap, input bit xn, input bit priv, input int kind);
        bit pr, pw, ur, uw;
        pr = 0; pw = 0; ur = 0; uw = 0;
        if (ap == 1) begin pr = 1; pw = 1; end
        if (ap == 2) begin pr = 1; pw = 1; ur = 1; end
        if (ap == 3) begin pr = 1; pw = 1; ur = 1; uw = 1; end
        if (ap == 5) begin pr = 1; end
        if (ap == 6) begin pr = 1; ur = 1; end
        if (kind == 2 && xn) return 1'b0;
        if (kind == 1) return priv ? pw : uw;
        return priv ? pr : ur;
    endfunction

    function automatic logic [31:0] m_read(input int a);
        if (a == 0) return 32'd16 << 8;
        if (a == 1) return {29'd0, m_bg, 1'b0, m_en};
        if (a == 2) return 32'(m_sel);
        if (a >= 3 && a <= 10) return (a % 2 == 1) ? m_base[m_sel] : m_rasr[m_sel];
        return 32'd0;
    endfunction

    always @(posedge clk) begin
        e_valid = 0; e_hit = 0; e_region = 0; e_tex = 0;
        e_b = 0; e_c = 0; e_s = 0; e_xn = 0; e_fault = 0;
        if (!rst_n) begin
            for (int r = 0; r < 16; r++) begin
                m_base[r] = 32'd0;
                m_rasr[r] = 32'h0108_0000;
            end
            m_en = 0; m_bg = 1; m_sel = 0;
        end else begin
            if (acc_valid) begin
                int win;
                e_valid = 1;
                win = -1;
                if (m_en) begin
                    for (int r = 15; r >= 0; r--) begin
                        if (win < 0 && m_hits(r, acc_addr)) win = r;
                    end
                    if (win >= 0) begin
                        e_hit    = 1;
                        e_region = win;
                        e_b      = m_rasr[win][16];
                        e_c      = m_rasr[win][17];
                        e_s      = m_rasr[win][18];
                        e_tex    = m_rasr[win][21:19];
                        e_xn     = m_rasr[win][28];
                        e_fault  = !m_allowed(int'(m_rasr[win][26:24]), m_rasr[win][28],
                                              acc_priv, int'(acc_kind));
                    end else begin
                        e_fault = !(acc_priv && m_bg);
                    end
                end
            end
            if (cfg_we) begin
                int a;
                a = int'(cfg_addr);
                if (a == 1) begin m_en = cfg_wdata[0]; m_bg = cfg_wdata[2]; end
                if (a == 2) m_sel = int'(cfg_wdata[3:0]);
                if (a >= 3 && a <= 10) begin
                    if (a % 2 == 1) m_base[m_sel] = cfg_wdata & 32'hFFFF_FFE0;
                    else            m_rasr[m_sel] = cfg_wdata & 32'h173F_FF3F;
                end
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (res_valid !== e_valid || res_hit !== e_hit || int'(res_region) != e_region
                || res_tex !== e_tex || res_b !== e_b || res_c !== e_c || res_s !== e_s
                || res_xn !== e_xn || res_fault !== e_fault) begin
                n_bad++;
                $display("FAIL %s addr=%h: actual v%0b h%0b r%0d t%0d b%0b c%0b s%0b x%0b f%0b expected v%0b h%0b r%0d t%0d b%0b c%0b s%0b x%0b f%0b",
                    cur_req, acc_addr, res_valid, res_hit, res_region, res_tex, res_b, res_c,
                    res_s, res_xn, res_fault, e_valid, e_hit, e_region, e_tex, e_b, e_c,
                    e_s, e_xn, e_fault);
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        cfg_addr = 4'(a); cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic check_rd(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        cfg_addr = 4'(a);
        #1;
        n_cmp++;
        if (cfg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s reg %0d: actual %h expected %h", req, a, cfg_rdata, exp);
        end
    endtask

    task automatic acc(input logic [31:0] a, input bit p, input int k);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_priv = p; acc_kind = 2'(k);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values (literal expectations)
        check_rd(0, 32'h0000_1000, "R1");
        check_rd(1, 32'h0000_0004, "R1");
        check_rd(2, 32'h0, "R1");
        check_rd(3, 32'h0, "R1");
        check_rd(4, 32'h0108_0000, "R1");

        // R2 disabled: everything passes
        cur_req = "R2";
        acc(32'h0000_1234, 0, 1);
        acc(32'h2000_0000, 0, 2);

        // R10 programming through main view and aliases
        cur_req = "R10";
        wr(2, 0);  wr(3, 32'h0);         wr(4, mk(1, 31, 0, 1, 1, 0, 1, 3, 0));
        wr(2, 1);  wr(5, 32'h2000_0000); wr(6, mk(1, 15, 0, 0, 0, 1, 0, 6, 0));
        wr(2, 2);  wr(7, 32'h2000_4000); wr(8, mk(1, 11, 8'h02, 1, 0, 0, 2, 1, 1));
        wr(2, 5);  wr(9, 32'h4000_0000); wr(10, mk(1, 4, 0, 0, 1, 1, 4, 2, 0));
        wr(2, 15); wr(3, 32'h8001_2345); wr(4, mk(1, 19, 0, 0, 0, 0, 7, 0, 0));
        wr(2, 2);
        for (int a = 3; a <= 10; a++) check_rd(a, m_read(a), "R10");
        check_rd(5, 32'h2000_4000, "R10");
        wr(12, 32'hFFFF_FFFF);
        wr(0, 32'hFFFF_FFFF);
        for (int a = 0; a <= 15; a++) check_rd(a, m_read(a), "R10");

        cur_req = "R2";
        acc(32'h8000_0004, 0, 1);
        wr(1, 32'h5);

        // R4 overlap and R12 attribute outputs
        cur_req = "R4";
        acc(32'h2000_0100, 0, 0);
        acc(32'h2000_4010, 1, 0);
        acc(32'h1000_0000, 0, 1);
        acc(32'h8000_0004, 1, 0);
        acc(32'h8010_0000, 1, 0);
        cur_req = "R12";
        acc(32'h2000_4800, 1, 1);
        acc(32'h4000_0008, 1, 0);

        // R5 subregion fall-through
        cur_req = "R5";
        acc(32'h2000_4210, 1, 0);
        acc(32'h2000_4400, 1, 0);
        acc(32'h2000_43FC, 0, 1);

        // R9 execute-never
        cur_req = "R9";
        acc(32'h2000_4010, 1, 2);
        acc(32'h2000_0010, 0, 2);
        acc(32'h2000_4010, 1, 3);

        // R8 permission matrix on region 5
        cur_req = "R8";
        wr(2, 5);
        for (int ap = 0; ap < 8; ap++) begin
            wr(4, mk(1, 4, 0, 0, 1, 1, 4, ap, 0));
            for (int p = 0; p < 2; p++)
                for (int k = 0; k < 4; k++) acc(32'h4000_0010, p[0], k);
        end

        // R3 size clamp, edges, misaligned base
        cur_req = "R3";
        wr(4, mk(1, 4, 0, 0, 0, 0, 3, 3, 0));
        acc(32'h4000_001C, 0, 0);
        acc(32'h4000_0020, 0, 0);
        wr(4, mk(1, 2, 0, 0, 0, 0, 3, 3, 0));
        acc(32'h4000_001F, 0, 1);
        acc(32'h4000_0020, 0, 1);
        wr(4, mk(1, 8, 8'h80, 0, 0, 0, 3, 3, 0));
        acc(32'h4000_01F0, 0, 0);
        acc(32'h4000_0100, 0, 0);
        acc(32'h800F_FFFC, 1, 0);
        acc(32'h7FFF_FFFC, 1, 0);

        // R6 / R7 fallback
        wr(2, 0); wr(4, 32'h0);
        cur_req = "R6";
        acc(32'h1000_0000, 1, 0);
        acc(32'h1000_0000, 1, 2);
        cur_req = "R7";
        acc(32'h1000_0000, 0, 0);
        wr(1, 32'h1);
        acc(32'h1000_0000, 1, 1);
        acc(32'h2000_0000, 1, 0);

        // R11 back-to-back
        cur_req = "R11";
        @(negedge clk);
        acc_valid = 1; acc_addr = 32'h2000_0000; acc_priv = 0; acc_kind = 0;
        @(negedge clk);
        acc_addr = 32'h1000_0000;
        @(negedge clk);
        acc_addr = 32'h8000_0000; acc_priv = 1;
        @(negedge clk);
        acc_valid = 0;
        repeat (2) @(negedge clk);

        cur_req = "R2";
        wr(1, 32'h0);
        acc(32'h1000_0000, 0, 1);
        acc(32'h8000_0000, 0, 2);
        repeat (2) @(negedge clk);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule